// File: doc/BRIEF.md
# Dual-Panel Flash Swap Controller

This block carries out a software-requested exchange of two flash panels in the program address space. The CPU presents a swap request together with a 128-bit sequence word and a configuration input that permits or forbids swapping. The block checks whether the word is well formed. A well-formed word holds a 12-bit count, the bitwise inverse of that count, and zeros in every reserved bit. The block then commits, refuses or skips the swap. The result is reported through a zero flag, a sticky software-swap status bit and a one-cycle completion pulse.

On a committed swap, the active-panel bit toggles, and the block XORs it into the panel-select bit of every fetch address. The next instruction fetch is held off while the block sends a one-cycle invalidate pulse to the instruction cache and stream buffer and waits for their done response. After that response, fetches go through with the new mapping. The configuration snapshot is loaded only by its own load strobe, so a swap never changes it. A swap request that arrives right after another swap request, or while a swap is still in progress, is dropped and raises a sticky protocol-error flag.

Top module: `pswap_ctrl`

## Requirements
- R1: After reset, `active_panel`, `zflag`, `soft_swap`, `proto_err`, `inv_pulse`, `fetch_stall` and `swap_done` are all 0.
- R2: A sequence word is valid only when bits [23:12] are the bitwise inverse of bits [11:0] and bits [127:24] are all zero. The end values 12'h000 and 12'hFFF are valid when paired with their inverse.
- R3: For an accepted request with `swap_en`=1 and a valid word, the cycle after the request shows `active_panel` toggled, `zflag`=1 and `soft_swap`=1.
- R4: For an accepted request with `swap_en`=1 and an invalid word, the cycle after the request shows `swap_done`=1, `zflag`=0, `active_panel` unchanged, `soft_swap` unchanged and `fetch_stall`=0.
- R5: For an accepted request with `swap_en`=0, `swap_done` is 0 in the first cycle after the request and 1 in the second. `active_panel`, `zflag`, `soft_swap` and `proto_err` stay unchanged.
- R6: After a committed swap, `inv_pulse` is high for exactly the one cycle after the request. `fetch_stall` is high from that cycle until the clock edge at which `inv_done` is seen. At that edge `swap_done` pulses and the stall drops.
- R7: `fetch_gnt` equals `fetch_req` while `fetch_stall` is 0 and is 0 while the stall is high. `fetch_map_addr` equals `fetch_addr` with bit `PANEL_BIT` (default 23) XORed with `active_panel`.
- R8: `cfg_out` takes `cfg_in` only on a clock edge where `cfg_load` is 1. A swap leaves it unchanged.
- R9: A `swap_req` in the cycle right after an accepted request, or while a swap is in progress, is ignored (no change to the panel, flag or done) and sets the sticky `proto_err`.
- R10: Once set, `soft_swap` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_req | input | 1 | One-cycle swap request from the CPU |
| swap_word | input | 128 | Sequence word supplied with the request |
| swap_en | input | 1 | Configuration: swapping permitted |
| cfg_load | input | 1 | Boot-time strobe that loads the configuration snapshot |
| cfg_in | input | 16 | Configuration value to load |
| cfg_out | output | 16 | Held configuration snapshot |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 24 | Logical fetch address |
| fetch_gnt | output | 1 | Fetch allowed this cycle |
| fetch_map_addr | output | 24 | Fetch address after panel remapping |
| fetch_stall | output | 1 | Fetch held during invalidation |
| inv_pulse | output | 1 | One-cycle invalidate to cache and stream buffer |
| inv_done | input | 1 | Invalidation complete |
| active_panel | output | 1 | Current panel mapping |
| zflag | output | 1 | Result flag: 1 when the swap was committed |
| soft_swap | output | 1 | Sticky flag: a software swap has happened |
| proto_err | output | 1 | Sticky flag: a back-to-back or busy request was seen |
| swap_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a second request that lands in the exact cycle after a request that finished at once. This happens after a refused word, where the controller is already idle again and only the one-cycle acceptance history blocks the new request. The stimulus sends an invalid word and then keeps `swap_req` high for one more cycle with a valid word. A correct design must not toggle the panel, must set `proto_err`, and must not produce a second completion. The other timing-sensitive case is holding `inv_done` low for several cycles while the fetch port is requesting. This shows the grant stays blocked for the whole invalidation and reopens with the remapped panel bit.

// File: rtl/pswap_pkg.sv
package pswap_pkg;

  localparam int unsigned SEQ_W_D  = 12;
  localparam int unsigned WORD_W_D = 128;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NOP  = 2'd1,
    ST_WAIT = 2'd2
  } swap_state_e;

  // Count and inverse must be exact complements.
  function automatic logic pair_matches(input logic [SEQ_W_D-1:0] cnt,
                                        input logic [SEQ_W_D-1:0] inv);
    return (cnt ^ inv) == {SEQ_W_D{1'b1}};
  endfunction

endpackage

// File: rtl/pswap_validator.sv
module pswap_validator #(
  parameter int unsigned WORD_W = 128,
  parameter int unsigned SEQ_W  = 12
) (
  input  logic [WORD_W-1:0] word,
  output logic              valid
);
  localparam int unsigned RSV_LO = 2 * SEQ_W;
  localparam int unsigned RSV_W  = WORD_W - RSV_LO;

  logic pair_ok;
  logic rsv_zero;

  assign pair_ok  = pswap_pkg::pair_matches(word[SEQ_W-1:0], word[RSV_LO-1:SEQ_W]);
  assign rsv_zero = (word[WORD_W-1:RSV_LO] == {RSV_W{1'b0}});
  assign valid    = pair_ok && rsv_zero;
endmodule

// File: rtl/pswap_seq.sv
module pswap_seq
  import pswap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic en,
  input  logic valid,
  input  logic inv_done,
  output logic active_panel,
  output logic zflag,
  output logic soft_swap,
  output logic proto_err,
  output logic inv_pulse,
  output logic stall,
  output logic done,
  output logic acc_ok,
  output logic acc_bad,
  output logic acc_nop
);
  swap_state_e state;
  logic        last_acc;
  logic        busy;
  logic        accept;
  logic        reject;

  assign busy    = (state != ST_IDLE) || last_acc;
  assign accept  = req && !busy;
  assign reject  = req && busy;
  assign acc_ok  = accept && en && valid;
  assign acc_bad = accept && en && !valid;
  assign acc_nop = accept && !en;
  assign stall   = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      last_acc     <= 1'b0;
      active_panel <= 1'b0;
      zflag        <= 1'b0;
      soft_swap    <= 1'b0;
      proto_err    <= 1'b0;
      inv_pulse    <= 1'b0;
      done         <= 1'b0;
    end else begin
      last_acc  <= accept;
      inv_pulse <= acc_ok;
      done      <= 1'b0;
      if (reject) proto_err <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (acc_ok) begin
            active_panel <= !active_panel;
            zflag        <= 1'b1;
            soft_swap    <= 1'b1;
            state        <= ST_WAIT;
          end else if (acc_bad) begin
            zflag <= 1'b0;
            done  <= 1'b1;
          end else if (acc_nop) begin
            state <= ST_NOP;
          end
        end
        ST_NOP: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        ST_WAIT: begin
          if (inv_done) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pswap_fetch.sv
module pswap_fetch #(
  parameter int unsigned AW        = 24,
  parameter int unsigned PANEL_BIT = 23
) (
  input  logic          panel,
  input  logic          stall,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          gnt,
  output logic [AW-1:0] map_addr
);
  localparam logic [AW-1:0] PMASK = AW'(1) << PANEL_BIT;

  assign gnt      = req && !stall;
  assign map_addr = panel ? (addr ^ PMASK) : addr;
endmodule

// File: rtl/pswap_ctrl.sv
module pswap_ctrl #(
  parameter int unsigned WORD_W    = 128,
  parameter int unsigned SEQ_W     = 12,
  parameter int unsigned AW        = 24,
  parameter int unsigned PANEL_BIT = 23,
  parameter int unsigned CFG_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_req,
  input  logic [WORD_W-1:0] swap_word,
  input  logic              swap_en,
  input  logic              cfg_load,
  input  logic [CFG_W-1:0]  cfg_in,
  output logic [CFG_W-1:0]  cfg_out,
  input  logic              fetch_req,
  input  logic [AW-1:0]     fetch_addr,
  output logic              fetch_gnt,
  output logic [AW-1:0]     fetch_map_addr,
  output logic              fetch_stall,
  output logic              inv_pulse,
  input  logic              inv_done,
  output logic              active_panel,
  output logic              zflag,
  output logic              soft_swap,
  output logic              proto_err,
  output logic              swap_done
);
  logic word_valid;
  logic acc_ok;
  logic acc_bad;
  logic acc_nop;

  pswap_validator #(.WORD_W(WORD_W), .SEQ_W(SEQ_W)) u_val (
    .word  (swap_word),
    .valid (word_valid)
  );

  pswap_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (swap_req),
    .en           (swap_en),
    .valid        (word_valid),
    .inv_done     (inv_done),
    .active_panel (active_panel),
    .zflag        (zflag),
    .soft_swap    (soft_swap),
    .proto_err    (proto_err),
    .inv_pulse    (inv_pulse),
    .stall        (fetch_stall),
    .done         (swap_done),
    .acc_ok       (acc_ok),
    .acc_bad      (acc_bad),
    .acc_nop      (acc_nop)
  );

  pswap_fetch #(.AW(AW), .PANEL_BIT(PANEL_BIT)) u_fetch (
    .panel    (active_panel),
    .stall    (fetch_stall),
    .req      (fetch_req),
    .addr     (fetch_addr),
    .gnt      (fetch_gnt),
    .map_addr (fetch_map_addr)
  );

  // Configuration snapshot: written only by its own strobe (R8).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_out <= '0;
    else if (cfg_load) cfg_out <= cfg_in;
  end
endmodule

// File: rtl/pswap_chk.sv
module pswap_chk #(
  parameter int unsigned CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_ok,
  input logic             acc_bad,
  input logic             acc_nop,
  input logic             active_panel,
  input logic             zflag,
  input logic             soft_swap,
  input logic             proto_err,
  input logic             inv_pulse,
  input logic             inv_done,
  input logic             fetch_stall,
  input logic             fetch_req,
  input logic             fetch_gnt,
  input logic             cfg_load,
  input logic [CFG_W-1:0] cfg_out,
  input logic             swap_done
);
  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> zflag && soft_swap && (active_panel != $past(active_panel)));

  p_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> swap_done && !zflag && $stable(active_panel) && !fetch_stall);

  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_nop |=> !swap_done && $stable(active_panel) && $stable(zflag));

  p_inv_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |=> !inv_pulse);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && !inv_done) |=> fetch_stall);

  p_gnt_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !fetch_gnt);

  p_gnt_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_stall && fetch_req) |-> fetch_gnt);

  p_cfg_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_out));

  p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_soft_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_swap |=> soft_swap);
endmodule

bind pswap_ctrl pswap_chk #(.CFG_W(CFG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_ok       (acc_ok),
  .acc_bad      (acc_bad),
  .acc_nop      (acc_nop),
  .active_panel (active_panel),
  .zflag        (zflag),
  .soft_swap    (soft_swap),
  .proto_err    (proto_err),
  .inv_pulse    (inv_pulse),
  .inv_done     (inv_done),
  .fetch_stall  (fetch_stall),
  .fetch_req    (fetch_req),
  .fetch_gnt    (fetch_gnt),
  .cfg_load     (cfg_load),
  .cfg_out      (cfg_out),
  .swap_done    (swap_done)
);

// File: tb/test_pswap_ctrl.sv
`timescale 1ns/1ps
module test_pswap_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         swap_req = 1'b0;
  logic [127:0] swap_word = '0;
  logic         swap_en = 1'b1;
  logic         cfg_load = 1'b0;
  logic [15:0]  cfg_in = '0;
  logic [15:0]  cfg_out;
  logic         fetch_req = 1'b0;
  logic [23:0]  fetch_addr = '0;
  logic         fetch_gnt;
  logic [23:0]  fetch_map_addr;
  logic         fetch_stall;
  logic         inv_pulse;
  logic         inv_done = 1'b0;
  logic         active_panel;
  logic         zflag;
  logic         soft_swap;
  logic         proto_err;
  logic         swap_done;

  always #2.5 clk = ~clk;

  pswap_ctrl i_pswap_ctrl (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit m_panel = 0, m_z = 0, m_soft = 0;
  logic [2:0] sb_q[$];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [11:0] n);
    return {104'd0, ~n, n};
  endfunction

  function automatic bit word_ok(input logic [127:0] w);
    return (w[127:24] == 0) && ((w[23:12] + w[11:0]) == 12'hFFF) && ((w[23:12] & w[11:0]) == 0);
  endfunction

  // Monitor: compare each completion against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && swap_done) begin
      if (sb_q.size() == 0) begin
        check("R9 unexpected done", 1, 0);
      end else begin
        logic [2:0] e;
        e = sb_q.pop_front();
        check("R3/R4/R5 result {z,panel,soft}", {zflag, active_panel, soft_swap}, e);
      end
    end
  end

  // Driver: called at a negedge.
  task automatic do_swap(input logic [127:0] w, input bit en);
    bit ok;
    ok = en && word_ok(w);
    if (ok) begin m_panel = !m_panel; m_z = 1; m_soft = 1; end
    else if (en) m_z = 0;
    sb_q.push_back({m_z, m_panel, m_soft});
    swap_word = w; swap_en = en; swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    if (ok) begin
      check("R6 inv pulse high", inv_pulse, 1);
      check("R6 stall high", fetch_stall, 1);
      check("R7 grant blocked", fetch_gnt, 0);
      check("R3 panel toggled", active_panel, m_panel);
      @(negedge clk);
      check("R6 inv pulse single", inv_pulse, 0);
      @(negedge clk);
      check("R6 stall held", fetch_stall, 1);
      inv_done = 1'b1;
      @(negedge clk);
      inv_done = 1'b0;
      check("R6 stall released", fetch_stall, 0);
      check("R6 done pulse", swap_done, 1);
    end else if (en) begin
      check("R4 done next cycle", swap_done, 1);
      check("R4 no stall", fetch_stall, 0);
      check("R4 panel kept", active_panel, m_panel);
    end else begin
      check("R5 no done first cycle", swap_done, 0);
      @(negedge clk);
      check("R5 done second cycle", swap_done, 1);
      check("R5 no error", proto_err, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 panel", active_panel, 0);
    check("R1 zflag", zflag, 0);
    check("R1 soft", soft_swap, 0);
    check("R1 perr", proto_err, 0);
    check("R1 inv", inv_pulse, 0);
    check("R1 stall", fetch_stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 24'h000123;
    @(negedge clk);
    check("R7 grant idle", fetch_gnt, 1);
    check("R7 addr panel0", fetch_map_addr, 24'h000123);
    cfg_in = 16'hA5A5; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; cfg_in = 16'h1234;
    check("R8 cfg loaded", cfg_out, 16'hA5A5);

    do_swap(mk(12'h5A3), 1);
    check("R7 addr panel1", fetch_map_addr, 24'h800123);
    check("R8 cfg kept over swap", cfg_out, 16'hA5A5);
    check("R7 grant after", fetch_gnt, 1);

    do_swap({104'd0, 12'hA5D, 12'h5A3}, 1);            // R2 bad inverse
    check("R10 soft sticky", soft_swap, 1);
    do_swap(mk(12'h5A3) | (128'd1 << 100), 1);        // R2 reserved bit
    do_swap(mk(12'h0FF), 0);                          // R5 disabled
    check("R5 zflag kept", zflag, 0);
    do_swap(mk(12'h000), 1);                          // R2 boundary low
    check("R2 zero count accepted", active_panel, 0);
    do_swap(mk(12'hFFF), 1);                          // R2 boundary high
    check("R2 full count accepted", zflag, 1);

    // R9: refused request followed at once by a valid one.
    m_z = 0;
    sb_q.push_back({1'b0, m_panel, m_soft});
    swap_word = 128'd7; swap_en = 1'b1; swap_req = 1'b1;
    @(negedge clk);
    swap_word = mk(12'h321);
    @(negedge clk);
    swap_req = 1'b0;
    check("R9 perr set", proto_err, 1);
    check("R9 panel unchanged", active_panel, m_panel);
    check("R9 no stall", fetch_stall, 0);
    repeat (3) @(negedge clk);
    check("R9 perr sticky", proto_err, 1);
    check("R9 queue drained", sb_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule